// File: doc/BRIEF.md
# ADC Channel Scan Sequencer

This block drives an external analog-to-digital converter through a programmable range of up to eight input channels. Software loads an 8-bit control byte that holds a scan mode, a first channel and a last channel. A trigger starts the scan. For each channel the block sends a one-cycle start pulse together with a channel select. It then waits for the converter's done strobe, latches the result and raises a sticky end-of-conversion flag.

Channels are visited in ascending order, and the count wraps from 7 to 0. Four modes set when a scan ends and how a trigger that arrives mid-scan is treated:

- Mode 00 converts the range once and can be restarted.
- Mode 01 converts the range once and cannot be restarted.
- Mode 10 loops over the range without end.
- Mode 11 converts one channel per trigger.

The middle field of the control byte reads back the live channel while a scan is active.

Top module: `adcseq_top`

## Requirements
- R1: After a synchronous reset the control byte reads 0x00, and busy, eoc, conv_start and result are all 0.
- R2: The control byte places the mode in bits 7:6, the first channel in bits 5:3 and the last channel in bits 2:0. When the block is idle, a write stores the whole byte and the same value reads back.
- R3: An accepted trigger starts a scan, and the channels are visited in ascending order from the first channel to the last, wrapping from 7 to 0. If first equals last, one channel is converted. Each conversion raises conv_start for exactly one cycle while conv_ch shows the channel. Trigger and done inputs are ignored in the cycle conv_start is high.
- R4: In modes 00 and 01 the scan returns to idle (busy low, no further pulse) right after the done of the last channel.
- R5: In mode 00, a trigger during a conversion restarts the scan at the first channel. A done that arrives in that same cycle is discarded and the result is not updated.
- R6: In modes 01 and 10, a trigger while busy has no effect on the channel sequence.
- R7: Mode 10 jumps from the last channel back to the first channel and never drops busy on its own.
- R8: Mode 11 converts one channel and then holds, still busy and issuing no pulse, until the next trigger. That trigger converts the next channel, and after the last channel the next one is the first channel. A trigger during a conversion in mode 11 is ignored.
- R9: The middle field (bits 5:3) reads the channel under conversion while converting, the channel just converted while holding in mode 11, and the stored first channel when idle.
- R10: On an accepted done, result takes conv_data and eoc is set. eoc stays set until an eoc_clr pulse. If eoc_clr and an accepted done arrive in the same cycle, eoc is set.
- R11: busy rises with the accepted trigger. While busy, a write with an unchanged mode field is ignored. A write with a different mode field stops the scan (busy low the next cycle) and updates only the mode field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Control byte write strobe |
| cfg_wdata | input | 8 | Control byte write data |
| cfg_rdata | output | 8 | Control byte readback |
| eoc_clr | input | 1 | Clear pulse for the end-of-conversion flag |
| trig | input | 1 | Scan start trigger |
| conv_start | output | 1 | One-cycle start pulse to the converter |
| conv_ch | output | 3 | Channel select to the converter |
| conv_done | input | 1 | Converter done strobe |
| conv_data | input | 10 | Converter result |
| result | output | 10 | Latched last result |
| eoc | output | 1 | Sticky end-of-conversion flag |
| busy | output | 1 | Scan active |

## Verification
Both single-shot modes are swept over all 64 first/last channel pairs. The expected channel order is computed modulo 8, which separates plain ascending ranges from wrapped ranges and from the single-channel case. In the locked mode, a trigger is injected mid-conversion to show that it is ignored. Directed runs cover the remaining behaviours:
- a restart trigger that coincides with a done;
- a wrapped continuous loop followed by blocked and mode-changing writes;
- a paused scan that wraps back to its first channel and checks readback in the holding state;
- the eoc set-over-clear collision.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
  typedef enum logic [1:0] {
    MD_SS_RESTART = 2'b00,
    MD_SS_LOCK    = 2'b01,
    MD_CONT       = 2'b10,
    MD_PAUSE      = 2'b11
  } scan_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_HOLD = 2'd2
  } seq_state_e;
endpackage

// File: rtl/adcseq_ctrl_reg.sv
module adcseq_ctrl_reg
  import adcseq_pkg::*;
#(
  parameter int CH_W = 3,
  localparam int CTRL_W = 2 + 2 * CH_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              busy,
  output scan_mode_e        mode,
  output logic [CH_W-1:0]   first_ch,
  output logic [CH_W-1:0]   last_ch,
  output logic              force_stop
);
  scan_mode_e wr_mode;
  assign wr_mode    = scan_mode_e'(wr_data[CTRL_W-1 -: 2]);
  assign force_stop = wr_en && busy && (wr_mode != mode);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode     <= MD_SS_RESTART;
      first_ch <= '0;
      last_ch  <= '0;
    end else if (wr_en) begin
      if (!busy) begin
        mode     <= wr_mode;
        first_ch <= wr_data[2*CH_W-1 -: CH_W];
        last_ch  <= wr_data[CH_W-1:0];
      end else if (force_stop) begin
        mode <= wr_mode;
      end
    end
  end
endmodule

// File: rtl/adcseq_fsm.sv
module adcseq_fsm
  import adcseq_pkg::*;
#(
  parameter int CH_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  scan_mode_e      mode,
  input  logic [CH_W-1:0] first_ch,
  input  logic [CH_W-1:0] last_ch,
  input  logic            force_stop,
  input  logic            trig,
  input  logic            conv_done,
  output logic            busy,
  output logic            conv_start,
  output logic [CH_W-1:0] cur_ch,
  output logic            capture
);
  seq_state_e      state;
  logic            live;
  logic            restart;
  logic            at_last;
  logic [CH_W-1:0] next_ch;

  assign live    = (state == ST_CONV) && !conv_start;
  assign restart = live && trig && (mode == MD_SS_RESTART);
  assign capture = live && conv_done && !restart && !force_stop;
  assign at_last = (cur_ch == last_ch);
  assign next_ch = at_last ? first_ch : cur_ch + 1'b1;
  assign busy    = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cur_ch     <= '0;
      conv_start <= 1'b0;
    end else begin
      conv_start <= 1'b0;
      if (force_stop) begin
        state <= ST_IDLE;
      end else begin
        case (state)
          ST_IDLE: begin
            if (trig) begin
              state      <= ST_CONV;
              cur_ch     <= first_ch;
              conv_start <= 1'b1;
            end
          end
          ST_CONV: begin
            if (restart) begin
              cur_ch     <= first_ch;
              conv_start <= 1'b1;
            end else if (capture) begin
              case (mode)
                MD_PAUSE: state <= ST_HOLD;
                MD_CONT: begin
                  cur_ch     <= next_ch;
                  conv_start <= 1'b1;
                end
                default: begin
                  if (at_last) begin
                    state <= ST_IDLE;
                  end else begin
                    cur_ch     <= next_ch;
                    conv_start <= 1'b1;
                  end
                end
              endcase
            end
          end
          ST_HOLD: begin
            if (trig) begin
              state      <= ST_CONV;
              cur_ch     <= next_ch;
              conv_start <= 1'b1;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/adcseq_result.sv
module adcseq_result #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             capture,
  input  logic [RES_W-1:0] conv_data,
  input  logic             eoc_clr,
  output logic [RES_W-1:0] result,
  output logic             eoc
);
  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      eoc    <= 1'b0;
    end else begin
      if (capture) begin
        result <= conv_data;
      end
      if (capture) begin
        eoc <= 1'b1;
      end else if (eoc_clr) begin
        eoc <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/adcseq_top.sv
module adcseq_top
  import adcseq_pkg::*;
#(
  parameter int CH_W  = 3,
  parameter int RES_W = 10,
  localparam int CTRL_W = 2 + 2 * CH_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [CTRL_W-1:0] cfg_wdata,
  output logic [CTRL_W-1:0] cfg_rdata,
  input  logic              eoc_clr,
  input  logic              trig,
  output logic              conv_start,
  output logic [CH_W-1:0]   conv_ch,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_data,
  output logic [RES_W-1:0]  result,
  output logic              eoc,
  output logic              busy
);
  scan_mode_e      mode;
  logic [CH_W-1:0] first_ch;
  logic [CH_W-1:0] last_ch;
  logic [CH_W-1:0] cur_ch;
  logic            force_stop;
  logic            capture;

  adcseq_ctrl_reg #(.CH_W(CH_W)) u_reg (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (cfg_wr),
    .wr_data    (cfg_wdata),
    .busy       (busy),
    .mode       (mode),
    .first_ch   (first_ch),
    .last_ch    (last_ch),
    .force_stop (force_stop)
  );

  adcseq_fsm #(.CH_W(CH_W)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .mode       (mode),
    .first_ch   (first_ch),
    .last_ch    (last_ch),
    .force_stop (force_stop),
    .trig       (trig),
    .conv_done  (conv_done),
    .busy       (busy),
    .conv_start (conv_start),
    .cur_ch     (cur_ch),
    .capture    (capture)
  );

  adcseq_result #(.RES_W(RES_W)) u_res (
    .clk       (clk),
    .rst       (rst),
    .capture   (capture),
    .conv_data (conv_data),
    .eoc_clr   (eoc_clr),
    .result    (result),
    .eoc       (eoc)
  );

  assign conv_ch   = cur_ch;
  assign cfg_rdata = {mode, (busy ? cur_ch : first_ch), last_ch};
endmodule

// File: rtl/adcseq_chk.sv
module adcseq_chk #(
  parameter int CH_W  = 3,
  parameter int RES_W = 10,
  localparam int CTRL_W = 2 + 2 * CH_W
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_wr,
  input logic [CTRL_W-1:0] cfg_wdata,
  input logic [CTRL_W-1:0] cfg_rdata,
  input logic              eoc_clr,
  input logic              trig,
  input logic              conv_start,
  input logic [CH_W-1:0]   conv_ch,
  input logic              conv_done,
  input logic [RES_W-1:0]  result,
  input logic              eoc,
  input logic              busy
);
  logic mode_same;
  assign mode_same = (cfg_wdata[CTRL_W-1 -: 2] == cfg_rdata[CTRL_W-1 -: 2]);

  AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start); // R3
  AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> busy); // R11
  AST_RDBACK_LIVE: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cfg_rdata[2*CH_W-1 -: CH_W] == conv_ch)); // R9
  AST_EOC_STICKY: assert property (@(posedge clk) disable iff (rst)
    (eoc && !eoc_clr) |=> eoc); // R10
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !conv_done |=> $stable(result)); // R10
  AST_WR_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (busy && cfg_wr && mode_same) |=> $stable(cfg_rdata[CH_W-1:0])); // R11
  AST_FORCE_STOP: assert property (@(posedge clk) disable iff (rst)
    (busy && cfg_wr && !mode_same) |=> (!busy && !conv_start)); // R11
  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (rst)
    (!busy && !trig) |=> !busy); // R11
endmodule

bind adcseq_top adcseq_chk #(.CH_W(CH_W), .RES_W(RES_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cfg_wr     (cfg_wr),
  .cfg_wdata  (cfg_wdata),
  .cfg_rdata  (cfg_rdata),
  .eoc_clr    (eoc_clr),
  .trig       (trig),
  .conv_start (conv_start),
  .conv_ch    (conv_ch),
  .conv_done  (conv_done),
  .result     (result),
  .eoc        (eoc),
  .busy       (busy)
);

// File: tb/tb_adcseq_top.sv
`timescale 1ns/1ps
module tb_adcseq_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       eoc_clr = 1'b0;
  logic       trig = 1'b0;
  logic       conv_start;
  logic [2:0] conv_ch;
  logic       conv_done = 1'b0;
  logic [9:0] conv_data = '0;
  logic [9:0] result;
  logic       eoc;
  logic       busy;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  adcseq_top dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .eoc_clr(eoc_clr), .trig(trig),
    .conv_start(conv_start), .conv_ch(conv_ch), .conv_done(conv_done),
    .conv_data(conv_data), .result(result), .eoc(eoc), .busy(busy)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfg_write(logic [7:0] v);
    cfg_wr = 1'b1; cfg_wdata = v;
    tick();
    cfg_wr = 1'b0;
  endtask

  task automatic pulse_trig();
    trig = 1'b1;
    tick();
    trig = 1'b0;
  endtask

  task automatic clear_eoc();
    eoc_clr = 1'b1;
    tick();
    eoc_clr = 1'b0;
  endtask

  // Called in the cycle conv_start is visible; ends after the done edge.
  task automatic finish_conv(logic [9:0] dat, bit with_trig, int ch);
    tick();
    if (with_trig) begin
      trig = 1'b1;
      tick();
      trig = 1'b0;
      chk(conv_start == 1'b0 && conv_ch == ch[2:0], "R6 trigger ignored while busy",
          int'(conv_ch), ch);
    end
    conv_done = 1'b1; conv_data = dat;
    tick();
    conv_done = 1'b0;
    chk(result == dat, "R10 result latched", int'(result), int'(dat));
    chk(eoc == 1'b1, "R10 eoc set", int'(eoc), 1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    int n;
    int ch;
    logic [9:0] dat;
    tick(); tick();
    rst = 1'b0;
    tick();
    // R1 reset state
    chk(cfg_rdata == 8'h00, "R1 control reset", int'(cfg_rdata), 0);
    chk(busy == 1'b0 && eoc == 1'b0 && conv_start == 1'b0, "R1 flags reset",
        int'({busy, eoc, conv_start}), 0);
    chk(result == 10'd0, "R1 result reset", int'(result), 0);

    // Sweep of both single-shot modes over every first/last pair
    for (int md = 0; md < 2; md++) begin
      for (int s = 0; s < 8; s++) begin
        for (int e = 0; e < 8; e++) begin
          cfg_write(8'((md << 6) | (s << 3) | e));
          chk(cfg_rdata == 8'((md << 6) | (s << 3) | e), "R2 idle write readback",
              int'(cfg_rdata), (md << 6) | (s << 3) | e);
          pulse_trig();
          chk(busy == 1'b1, "R11 busy after trigger", int'(busy), 1);
          n = ((e - s) & 7) + 1;
          for (int k = 0; k < n; k++) begin
            ch = (s + k) & 7;
            dat = 10'(((s * 64 + e * 8 + ch) * 2 + md) & 1023);
            chk(conv_start == 1'b1, "R3 start pulse", int'(conv_start), 1);
            chk(conv_ch == ch[2:0], "R3 channel order", int'(conv_ch), ch);
            chk(cfg_rdata[5:3] == ch[2:0], "R9 readback while converting",
                int'(cfg_rdata[5:3]), ch);
            finish_conv(dat, (md == 1) && (k == 0), ch);
            if (k == n - 1) begin
              chk(busy == 1'b0 && conv_start == 1'b0, "R4 single-shot ends",
                  int'({busy, conv_start}), 0);
              chk(cfg_rdata[5:3] == s[2:0], "R9 idle readback", int'(cfg_rdata[5:3]), s);
            end
          end
          clear_eoc();
          chk(eoc == 1'b0, "R10 eoc cleared", int'(eoc), 0);
        end
      end
    end

    // R5 restart in mode 00, with a coinciding done dropped
    cfg_write({2'b00, 3'd2, 3'd5});
    pulse_trig();
    finish_conv(10'h111, 1'b0, 2);
    chk(conv_ch == 3'd3 && conv_start == 1'b1, "R5 before restart", int'(conv_ch), 3);
    tick();
    trig = 1'b1; conv_done = 1'b1; conv_data = 10'h3AA;
    tick();
    trig = 1'b0; conv_done = 1'b0;
    chk(conv_start == 1'b1 && conv_ch == 3'd2, "R5 restart at first channel",
        int'(conv_ch), 2);
    chk(result == 10'h111, "R5 coinciding done dropped", int'(result), 'h111);
    for (int k = 0; k < 4; k++) begin
      chk(conv_ch == 3'(2 + k), "R5 sequence after restart", int'(conv_ch), 2 + k);
      finish_conv(10'(k + 40), 1'b0, 2 + k);
    end
    chk(busy == 1'b0, "R4 idle after restarted scan", int'(busy), 0);

    // R7 continuous with wrap 6,7,0,1
    cfg_write({2'b10, 3'd6, 3'd1});
    pulse_trig();
    for (int k = 0; k < 10; k++) begin
      ch = (6 + (k % 4)) & 7;
      chk(conv_start == 1'b1 && conv_ch == ch[2:0], "R7 continuous order",
          int'(conv_ch), ch);
      finish_conv(10'(k + 100), k == 5, ch);
      chk(busy == 1'b1, "R7 stays busy", int'(busy), 1);
    end
    // R11 blocked write with same mode
    cfg_write({2'b10, 3'd0, 3'd4});
    chk(cfg_rdata[2:0] == 3'd1 && busy == 1'b1, "R11 write blocked while busy",
        int'(cfg_rdata[2:0]), 1);
    // R11 mode change forces stop, other fields kept
    cfg_write({2'b01, 3'd0, 3'd4});
    chk(busy == 1'b0 && conv_start == 1'b0, "R11 forced stop", int'(busy), 0);
    chk(cfg_rdata == {2'b01, 3'd6, 3'd1}, "R11 only mode updated",
        int'(cfg_rdata), int'({2'b01, 3'd6, 3'd1}));

    // R8 pause mode 3,4 then wrap to 3
    cfg_write({2'b11, 3'd3, 3'd4});
    pulse_trig();
    chk(conv_ch == 3'd3 && conv_start == 1'b1, "R8 first channel", int'(conv_ch), 3);
    finish_conv(10'd7, 1'b0, 3);
    tick(); tick();
    chk(busy == 1'b1 && conv_start == 1'b0, "R8 holds without pulse",
        int'({busy, conv_start}), 2);
    chk(cfg_rdata[5:3] == 3'd3, "R9 paused readback", int'(cfg_rdata[5:3]), 3);
    pulse_trig();
    chk(conv_ch == 3'd4 && conv_start == 1'b1, "R8 next on trigger", int'(conv_ch), 4);
    finish_conv(10'd8, 1'b1, 4);
    chk(cfg_rdata[5:3] == 3'd4 && conv_start == 1'b0, "R9 paused readback last",
        int'(cfg_rdata[5:3]), 4);
    pulse_trig();
    chk(conv_ch == 3'd3 && conv_start == 1'b1, "R8 wraps to first", int'(conv_ch), 3);
    finish_conv(10'd9, 1'b0, 3);
    cfg_write({2'b00, 3'd3, 3'd4});
    chk(busy == 1'b0, "R11 stop from pause", int'(busy), 0);

    // R10 set wins over clear
    cfg_write({2'b01, 3'd7, 3'd7});
    clear_eoc();
    pulse_trig();
    tick();
    conv_done = 1'b1; conv_data = 10'h2C3; eoc_clr = 1'b1;
    tick();
    conv_done = 1'b0; eoc_clr = 1'b0;
    chk(eoc == 1'b1, "R10 set wins over clear", int'(eoc), 1);
    chk(result == 10'h2C3 && busy == 1'b0, "R3 single channel scan", int'(result), 'h2C3);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule